// File: doc/BRIEF.md
# I2C Bit-Rate Generator

This block derives the timing of an I2C master from a fast core clock. A 7-bit rate word sets two cascaded dividers: a linear stage that divides by (M+1) and a binary stage that divides by 2^(N+1). Each pulse out of the binary stage is one sample strobe. Ten sample strobes make one SCL period: five slots with SCL driven low, followed by five slots with SCL released high. The resulting SCL rate is Fclk / (10·(M+1)·2^(N+1)).

The byte controller uses the strobe as its bit-engine enable and the phase output to drive or release SCL. A rate word presented while the generator is running is picked up only when the current SCL period completes, so an SCL period is never cut short or stretched part-way through. A parameter selects a build variant in which the binary stage divides by 2^N. While the enable input is low, every counter is held cleared and no strobes appear.

Top module: `i2c_rate_gen`

## Requirements
- R1: The rate word carries M (0..15) in bits 6:3 and N (0..7) in bits 2:0. While running, `sample_tick` pulses for one cycle every (M+1)·2^(N+1) clock cycles.
- R2: Call cycle 0 the first cycle with `enable` high. The first `sample_tick` then appears in cycle D-1, where D is the strobe interval from R1.
- R3: One SCL period holds exactly ten strobe slots. `scl_high` is 0 during slots 0..4 and 1 during slots 5..9. It rises in cycle 5·D and falls in cycle 10·D, both counted from the cycle-0 origin of R2.
- R4: After synchronous reset the held rate word is 0x44 (M=8, N=4). If `enable` is high when reset is released, the first strobe comes at cycle 287 whatever `baud_i` holds.
- R5: A change of `baud_i` while running takes effect only after the tenth strobe of the current period. `period_end` marks that strobe.
- R6: While `enable` is low, `sample_tick` and `period_end` stay 0 and `scl_high` reads 1. Raising `enable` again restarts at slot 0, using the `baud_i` value present in the cycle before.
- R7: With parameter POW_EXTRA = 0 the binary stage divides by 2^N. With the 0x44 reset word the strobe interval is then 144 cycles, and with word 0x00 a strobe appears on every cycle.
- R8: With word 0x00 (M=0, N=0) the strobe interval is 2 cycles and the SCL period is 20 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run control. Low holds all counters cleared |
| baud_i | input | 7 | Rate word: M in bits 6:3, N in bits 2:0 |
| sample_tick | output | 1 | One-cycle sample strobe |
| scl_high | output | 1 | 1 = SCL released high, 0 = SCL driven low |
| period_end | output | 1 | Strobe that closes an SCL period |

## Verification
The assertions assume that `rst` is asserted in the first cycle. They also assume that `enable` and `baud_i` change only between clock edges, so every rate word seen at an edge is a whole, stable value. The bench changes both inputs only on the falling clock edge, and it raises reset from time zero before it lets the counters run. The rate-hold assertion relies on `baud_i` being sampled only at a period boundary or while the block is disabled. The stimulus therefore changes the word mid-period to show that the running period still finishes at the old rate.

// File: rtl/i2c_rate_pkg.sv
package i2c_rate_pkg;

    localparam int M_W      = 4;
    localparam int N_W      = 3;
    localparam int BAUD_W   = M_W + N_W;
    localparam int SLOTS    = 10;
    localparam int HALF     = SLOTS / 2;
    localparam int SLOT_W   = $clog2(SLOTS);
    localparam int POW_W    = (1 << N_W) + 1;
    localparam logic [BAUD_W-1:0] BAUD_RST = 7'h44;

    // M in the upper field, N in the lower field
    typedef struct packed {
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
    } baud_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scl_phase_e;

    // Last count of the binary stage: 2^(n+extra) - 1
    function automatic logic [POW_W-1:0] pow_limit(input logic [N_W-1:0] n, input int extra);
        logic [POW_W-1:0] one;
        one = POW_W'(1);
        return (one << (int'(n) + extra)) - POW_W'(1);
    endfunction

endpackage

// File: rtl/rate_baud_hold.sv
module rate_baud_hold
    import i2c_rate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              boundary,
    input  logic [BAUD_W-1:0] baud_in,
    output baud_t             baud_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            baud_q <= baud_t'(BAUD_RST);
        end else if (!enable || boundary) begin
            baud_q <= baud_t'(baud_in);
        end
    end

    AST_BAUD_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(enable) && !$past(boundary) && !$past(rst)) |-> $stable(baud_q)); // R5

endmodule

// File: rtl/rate_lin_stage.sv
module rate_lin_stage
    import i2c_rate_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           enable,
    input  logic [M_W-1:0] m,
    output logic           lin_tick
);

    logic [M_W-1:0] cnt;

    assign lin_tick = enable && (cnt == m);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt <= '0;
        end else if (lin_tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + M_W'(1);
        end
    end

    AST_LIN_WRAP: assert property (@(posedge clk) disable iff (rst)
        lin_tick |=> (cnt == '0)); // R1

endmodule

// File: rtl/rate_pow_stage.sv
module rate_pow_stage
    import i2c_rate_pkg::*;
#(
    parameter int POW_EXTRA = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           enable,
    input  logic [N_W-1:0] n,
    input  logic           lin_tick,
    output logic           sample_tick
);

    logic [POW_W-1:0] cnt;
    logic [POW_W-1:0] last;

    assign last        = pow_limit(n, POW_EXTRA);
    assign sample_tick = lin_tick && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt <= '0;
        end else if (lin_tick) begin
            cnt <= sample_tick ? '0 : cnt + POW_W'(1);
        end
    end

    AST_POW_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (enable && !lin_tick) |=> $stable(cnt)); // R1

endmodule

// File: rtl/rate_slot_ctr.sv
module rate_slot_ctr
    import i2c_rate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       sample_tick,
    output logic       boundary,
    output scl_phase_e phase
);

    logic [SLOT_W-1:0] slot;

    assign boundary = sample_tick && (slot == SLOT_W'(SLOTS - 1));
    assign phase    = (slot >= SLOT_W'(HALF)) ? PH_HIGH : PH_LOW;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            slot <= '0;
        end else if (sample_tick) begin
            slot <= boundary ? '0 : slot + SLOT_W'(1);
        end
    end

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
        boundary |=> (slot == '0)); // R3
    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        $rose(enable) |-> (slot == '0)); // R6

endmodule

// File: rtl/i2c_rate_gen.sv
module i2c_rate_gen
    import i2c_rate_pkg::*;
#(
    parameter int POW_EXTRA = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [BAUD_W-1:0] baud_i,
    output logic              sample_tick,
    output logic              scl_high,
    output logic              period_end
);

    baud_t      baud_q;
    logic       lin_tick;
    logic       boundary;
    scl_phase_e phase;

    rate_baud_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .boundary (boundary),
        .baud_in  (baud_i),
        .baud_q   (baud_q)
    );

    rate_lin_stage u_lin (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .m        (baud_q.m),
        .lin_tick (lin_tick)
    );

    rate_pow_stage #(.POW_EXTRA(POW_EXTRA)) u_pow (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .n           (baud_q.n),
        .lin_tick    (lin_tick),
        .sample_tick (sample_tick)
    );

    rate_slot_ctr u_slot (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .sample_tick (sample_tick),
        .boundary    (boundary),
        .phase       (phase)
    );

    assign period_end = boundary;
    assign scl_high   = !enable || (phase == PH_HIGH);

    AST_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (!sample_tick && !period_end && scl_high)); // R6

endmodule

// File: tb/i2c_rate_gen_bench.sv
`timescale 1ns/1ps
module i2c_rate_gen_bench;

    typedef struct packed {
        logic [6:0]  baud;
        logic [15:0] div;
    } vec_t;

    // expected strobe interval (M+1)*2^(N+1), worked out by hand
    localparam vec_t VECS [6] = '{
        '{7'h00, 16'd2},     // M0 N0, R8
        '{7'h44, 16'd288},   // M8 N4
        '{7'h0B, 16'd32},    // M1 N3
        '{7'h50, 16'd22},    // M10 N0
        '{7'h07, 16'd256},   // M0 N7
        '{7'h7F, 16'd4096}   // M15 N7
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic [6:0] baud_i = 7'h00;
    logic       sample_tick, scl_high, period_end;
    logic       alt_tick, alt_high, alt_end;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    i2c_rate_gen u_i2c_rate_gen (
        .clk(clk), .rst(rst), .enable(enable), .baud_i(baud_i),
        .sample_tick(sample_tick), .scl_high(scl_high), .period_end(period_end)
    );

    i2c_rate_gen #(.POW_EXTRA(0)) u_i2c_rate_gen_alt (
        .clk(clk), .rst(rst), .enable(enable), .baud_i(baud_i),
        .sample_tick(alt_tick), .scl_high(alt_high), .period_end(alt_end)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // starts a run from cycle 0 at the current falling edge
    task automatic run_vec(input logic [6:0] b, input int d);
        int first = -1;
        int cnt = 0;
        int alt_first = -1;
        int ends = 0;
        logic s_lo = 1'b1, s_hi = 1'b0, s_wrap = 1'b1;
        @(negedge clk); enable = 1'b0; baud_i = b;
        @(negedge clk);
        @(negedge clk); enable = 1'b1;
        for (int k = 0; k <= 10 * d; k++) begin
            #1;
            if (sample_tick && k < 10 * d) begin
                cnt++;
                if (first < 0) first = k;
            end
            if (period_end && k < 10 * d) ends++;
            if (alt_tick && alt_first < 0) alt_first = k;
            if (k == 5 * d - 1) s_lo = scl_high;
            if (k == 5 * d)     s_hi = scl_high;
            if (k == 10 * d)    s_wrap = scl_high;
            @(negedge clk);
        end
        check(first == d - 1, "R1/R2 first strobe", first, d - 1);
        check(cnt == 10, "R3 strobes per period", cnt, 10);
        check(ends == 1 && period_end == 1'b0, "R5 one period_end", ends, 1);
        check(s_lo == 1'b0, "R3 scl low before slot 5", s_lo, 0);
        check(s_hi == 1'b1, "R3 scl high at slot 5", s_hi, 1);
        check(s_wrap == 1'b0, "R3 scl low after wrap", s_wrap, 0);
        if (b == 7'h00) check(alt_first == 0, "R7 variant word 0x00", alt_first, 0);
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int first;
        int alt_first;
        int n_tick;
        int t10;
        int t11;
        int bad;
        // R4: reset with enable high, baud_i ignored until boundary
        enable = 1'b1; baud_i = 7'h00; rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(sample_tick == 1'b0, "R4 no strobe in reset", sample_tick, 0);
        check(scl_high == 1'b0, "R4 scl low at slot 0", scl_high, 0);
        @(negedge clk); rst = 1'b0;
        first = -1; alt_first = -1;
        for (int k = 0; k < 300; k++) begin
            #1;
            if (sample_tick && first < 0) first = k;
            if (alt_tick && alt_first < 0) alt_first = k;
            @(negedge clk);
        end
        check(first == 287, "R4 reset word 0x44", first, 287);
        check(alt_first == 143, "R7 variant reset word", alt_first, 143);

        // table walk: R1 R2 R3 R8
        for (int i = 0; i < 6; i++) run_vec(VECS[i].baud, int'(VECS[i].div));

        // R6: disable while running
        @(negedge clk); enable = 1'b0;
        bad = 0;
        for (int k = 0; k < 40; k++) begin
            #1;
            if (sample_tick || period_end || !scl_high) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R6 quiet while disabled", bad, 0);

        // R5: mid-period change, 0x00 (D=2) then 0x0B (D=32)
        baud_i = 7'h00;
        @(negedge clk); enable = 1'b1;
        n_tick = 0; t10 = -1; t11 = -1;
        for (int k = 0; k < 80; k++) begin
            if (k == 3) baud_i = 7'h0B;
            #1;
            if (sample_tick) begin
                n_tick++;
                if (n_tick == 10) t10 = k;
                if (n_tick == 11) t11 = k;
            end
            @(negedge clk);
        end
        check(t10 == 19, "R5 old rate finishes period", t10, 19);
        check(t11 == 51, "R5 new rate after boundary", t11, 51);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule